// File: doc/BRIEF.md
# Masked Busy Combiner with History Capture and Duration Alarm

This block merges sixteen busy levels coming from readout units, or from further combiners of the same kind, into one busy level. Each input first passes through a two-stage synchronizer. A mask register can then exclude any input from the merge. The merged level `busy_out` is a plain level, so it can be wired straight into one `busy_in` bit of the next combiner in a chain.

Two observers run beside the merge. The first is a history recorder. On a programmable sample tick it stores the synchronized state of all sixteen inputs into a small FIFO. It keeps either the first window of samples or the most recent window. The second is a duration watchdog. It raises a latched interrupt when `busy_out` stays high for more than a programmable number of consecutive cycles.

A simple register port controls the block. Writes take effect at the clock edge. Read data appears on `reg_rdata` one cycle after `reg_rd`.

Register map (3-bit address, data width `LIM_W` = 24):

| Address | Name | Access |
|---|---|---|
| 0 | MASK | Bit i = 1 ignores input i. |
| 1 | CTRL | Bit 0 is capture enable. Bit 1 selects the mode: 0 keeps the first window, 1 keeps the last window. Writing bit 2 = 1 flushes the FIFO and restarts the sample tick. |
| 2 | SAMPLE_DIV | A tick occurs every SAMPLE_DIV+1 cycles. |
| 3 | LIMIT | Duration limit, in cycles. |
| 4 | STATUS | Bit 0 is the latched interrupt; writing bit 0 = 1 clears it. Bits [11:8] hold the FIFO level. |
| 5 | HIST | A read pops one entry. |
| 6 | STICKY | Write 1 to clear a bit. |
| 7 | LIVE | The synchronized inputs. |

History recorder states:
- `H_OFF`: no capture.
- `H_RUN`: capturing.
- `H_FROZEN`: the first window is full and capture has stopped.

History recorder transitions:
- enable moves `H_OFF`→`H_RUN`.
- clearing enable moves `H_RUN` or `H_FROZEN`→`H_OFF`.
- in first-window mode, the push that fills the FIFO moves `H_RUN`→`H_FROZEN`.
- flush moves any state to `H_RUN` if enabled, or to `H_OFF` if not.

Watchdog states:
- `WD_IDLE`: merged busy is low.
- `WD_COUNT`: counting consecutive busy cycles.
- `WD_TRIPPED`: the interrupt is latched.

Watchdog transitions:
- busy high moves `WD_IDLE`→`WD_COUNT`.
- busy low moves `WD_COUNT`→`WD_IDLE`.
- count ≥ LIMIT with busy still high moves `WD_COUNT`→`WD_TRIPPED`.
- an interrupt clear moves `WD_TRIPPED`→`WD_IDLE`.

Top module: `busy_combiner_monitor`

## Requirements
- R1: Each bit of `busy_in` passes through two flops. A change driven before clock edge k is visible on `busy_out` and in register LIVE (address 7, bit i = input i) after edge k+1.
- R2: `busy_out` is the OR of the synchronized inputs whose MASK bit (address 0, bit i = input i, 1 = ignored) is 0. A masked input has no effect on `busy_out`, and with all bits masked `busy_out` is low.
- R3: STICKY (address 6, bit i = input i) sets a bit whenever the synchronized input i is high, whatever the mask. A set bit stays set until a write to address 6 with that bit at 1.
- R4: While capture is enabled (CTRL bit 0), a sample of all sixteen synchronized inputs is pushed every SAMPLE_DIV+1 cycles. After a flush written at edge e, pushes occur at edges e+(SAMPLE_DIV+1)·n for n ≥ 1.
- R5: In first-window mode (CTRL bit 1 = 0), capture stops once the FIFO holds DEPTH samples. The first DEPTH samples are kept, and no further sample enters until a flush (a write to CTRL with bit 2 = 1), even after entries are read out.
- R6: In last-window mode (CTRL bit 1 = 1), a push into a full FIFO drops the oldest entry. The FIFO then holds the latest DEPTH samples, and the level never exceeds DEPTH.
- R7: A read of HIST (address 5) pops the oldest entry and returns it in bits [15:0], with bit 16 = 1. A read of an empty FIFO returns 0. STATUS bits [11:8] give the level.
- R8: The interrupt `irq` is set when `busy_out` is high for more than LIMIT consecutive cycles. Any low cycle of `busy_out` restarts the count.
- R9: `irq`, mirrored in STATUS bit 0, stays set until a write to STATUS with bit 0 = 1, even after `busy_out` falls.
- R10: After reset:
  - `busy_out`, `irq` and `reg_rdata` are 0.
  - MASK and STICKY read 0.
  - the FIFO is empty and capture is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_in | input | 16 | Asynchronous busy levels from downstream units |
| busy_out | output | 1 | Merged, masked busy level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Latched busy-duration interrupt |

## Verification
Internal faults show up at the ports as follows:
- A wrong synchronizer or mask state shows on `busy_out` within two cycles of the input change, so sweeping every input against several mask patterns exposes it at once.
- A fault in the history state machine or its pointers shows up only when the FIFO is read out, as a wrong order, a missing drop of the oldest entry, or samples accepted after the first window froze. Fixed A/B/C input phases against a known tick phase reveal it in the sequence popped.
- A watchdog counter that fails to restart, or an interrupt that fails to latch, shows on `irq` within LIMIT cycles of the offending busy pattern.

// File: rtl/busy_mon_pkg.sv
package busy_mon_pkg;

    localparam logic [2:0] A_MASK   = 3'd0;
    localparam logic [2:0] A_CTRL   = 3'd1;
    localparam logic [2:0] A_DIV    = 3'd2;
    localparam logic [2:0] A_LIMIT  = 3'd3;
    localparam logic [2:0] A_STATUS = 3'd4;
    localparam logic [2:0] A_HIST   = 3'd5;
    localparam logic [2:0] A_STICKY = 3'd6;
    localparam logic [2:0] A_LIVE   = 3'd7;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_LAST_BIT  = 1;
    localparam int CTRL_FLUSH_BIT = 2;
    localparam int STATUS_LVL_LSB = 8;

    typedef enum logic [1:0] {
        H_OFF    = 2'd0,
        H_RUN    = 2'd1,
        H_FROZEN = 2'd2
    } hist_state_t;

    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_COUNT   = 2'd1,
        WD_TRIPPED = 2'd2
    } wd_state_t;

endpackage

// File: rtl/busy_sync.sv
module busy_sync #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_q
);

    logic [N-1:0] stage1;
    logic [1:0]   age;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1[i] <= 1'b0;
                sync_q[i] <= 1'b0;
            end else begin
                stage1[i] <= async_in[i];
                sync_q[i] <= stage1[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    // R1
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (sync_q == $past(async_in, 2)));

endmodule

// File: rtl/busy_hist_fifo.sv
module busy_hist_fifo
    import busy_mon_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    parameter int DIV_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cap_en,
    input  logic                             last_mode,
    input  logic                             flush,
    input  logic [DIV_W-1:0]                 div,
    input  logic [W-1:0]                     sample,
    input  logic                             pop,
    output logic [W-1:0]                     head,
    output logic [$clog2(DEPTH+1)-1:0]       level,
    output logic                             empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    hist_state_t       state, state_nx;
    logic [DIV_W-1:0]  tick_cnt;
    logic              tick;
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [W-1:0]      mem [DEPTH];
    logic              full, pop_ok, push, drop, rd_adv;
    logic [LW-1:0]     level_nx;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign tick   = (tick_cnt == div);
    assign full   = (level == LW'(DEPTH));
    assign empty  = (level == '0);
    assign pop_ok = pop && !empty && !flush;
    assign head   = mem[rd_ptr];

    // output process: push / drop decisions of the recorder
    always_comb begin
        push = 1'b0;
        drop = 1'b0;
        unique case (state)
            H_OFF:    push = 1'b0;
            H_RUN:    push = tick && !flush && (!full || last_mode || pop_ok);
            H_FROZEN: push = 1'b0;
            default:  push = 1'b0;
        endcase
        drop     = push && full && !pop_ok;
        rd_adv   = pop_ok || drop;
        level_nx = level + LW'(push) - LW'(rd_adv);
    end

    // next-state process
    always_comb begin
        state_nx = state;
        if (flush) begin
            state_nx = cap_en ? H_RUN : H_OFF;
        end else begin
            unique case (state)
                H_OFF:    if (cap_en) state_nx = H_RUN;
                H_RUN: begin
                    if (!cap_en)
                        state_nx = H_OFF;
                    else if (!last_mode && push && level_nx == LW'(DEPTH))
                        state_nx = H_FROZEN;
                end
                H_FROZEN: if (!cap_en) state_nx = H_OFF;
                default:  state_nx = H_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= H_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
        end else if (flush) begin
            tick_cnt <= '0;
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
        end else begin
            tick_cnt <= tick ? '0 : tick_cnt + DIV_W'(1);
            if (push)   wr_ptr <= bump(wr_ptr);
            if (rd_adv) rd_ptr <= bump(rd_ptr);
            level <= level_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= sample;
    end

    // R5
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == H_FROZEN && !flush) |=> (level <= $past(level)));

    // R6
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R6
    last_full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == H_RUN && last_mode && full && tick && !pop && !flush && cap_en) |=> full);

endmodule

// File: rtl/busy_watchdog.sv
module busy_watchdog
    import busy_mon_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic [CNT_W-1:0] limit,
    input  logic             clr,
    output logic             irq
);

    wd_state_t        state, state_nx;
    logic [CNT_W-1:0] cnt;

    // next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            WD_IDLE:    if (busy) state_nx = WD_COUNT;
            WD_COUNT: begin
                if (!busy)
                    state_nx = WD_IDLE;
                else if (cnt >= limit)
                    state_nx = WD_TRIPPED;
            end
            WD_TRIPPED: if (clr) state_nx = WD_IDLE;
            default:    state_nx = WD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WD_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (state_nx == WD_COUNT)
            cnt <= (state == WD_COUNT) ? cnt + CNT_W'(1) : CNT_W'(1);
        else
            cnt <= '0;
    end

    // output process
    always_comb begin
        unique case (state)
            WD_TRIPPED: irq = 1'b1;
            default:    irq = 1'b0;
        endcase
    end

    // R8
    trip_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(busy));

    // R9
    irq_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);

endmodule

// File: rtl/busy_combiner_monitor.sv
module busy_combiner_monitor
    import busy_mon_pkg::*;
#(
    parameter int N_IN       = 16,
    parameter int HIST_DEPTH = 8,
    parameter int DIV_W      = 16,
    parameter int LIM_W      = 24,
    parameter int LIMIT_RST  = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  busy_in,
    output logic             busy_out,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [LIM_W-1:0] reg_wdata,
    output logic [LIM_W-1:0] reg_rdata,
    output logic             irq
);

    localparam int LW = $clog2(HIST_DEPTH + 1);

    logic [N_IN-1:0]  sync_q;
    logic [N_IN-1:0]  mask_q;
    logic [N_IN-1:0]  sticky_q;
    logic [N_IN-1:0]  sticky_clr;
    logic [N_IN-1:0]  head;
    logic             cap_en_q, last_mode_q;
    logic [DIV_W-1:0] div_q;
    logic [LIM_W-1:0] limit_q;
    logic [LW-1:0]    level;
    logic             empty;
    logic             flush, pop, irq_clr;
    logic [LIM_W-1:0] rd_mux;

    busy_sync #(.N(N_IN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (busy_in),
        .sync_q   (sync_q)
    );

    assign busy_out = |(sync_q & ~mask_q);

    assign flush   = reg_wr && (reg_addr == A_CTRL) && reg_wdata[CTRL_FLUSH_BIT];
    assign irq_clr = reg_wr && (reg_addr == A_STATUS) && reg_wdata[0];
    assign pop     = reg_rd && (reg_addr == A_HIST);
    assign sticky_clr = (reg_wr && reg_addr == A_STICKY) ? reg_wdata[N_IN-1:0] : '0;

    busy_hist_fifo #(.W(N_IN), .DEPTH(HIST_DEPTH), .DIV_W(DIV_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en_q),
        .last_mode (last_mode_q),
        .flush     (flush),
        .div       (div_q),
        .sample    (sync_q),
        .pop       (pop),
        .head      (head),
        .level     (level),
        .empty     (empty)
    );

    busy_watchdog #(.CNT_W(LIM_W)) u_wd (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy_out),
        .limit (limit_q),
        .clr   (irq_clr),
        .irq   (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q      <= '0;
            cap_en_q    <= 1'b0;
            last_mode_q <= 1'b0;
            div_q       <= '0;
            limit_q     <= LIM_W'(LIMIT_RST);
        end else if (reg_wr) begin
            unique case (reg_addr)
                A_MASK:  mask_q <= reg_wdata[N_IN-1:0];
                A_CTRL: begin
                    cap_en_q    <= reg_wdata[CTRL_EN_BIT];
                    last_mode_q <= reg_wdata[CTRL_LAST_BIT];
                end
                A_DIV:   div_q   <= reg_wdata[DIV_W-1:0];
                A_LIMIT: limit_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= (sticky_q & ~sticky_clr) | sync_q;
    end

    always_comb begin
        rd_mux = '0;
        unique case (reg_addr)
            A_MASK:   rd_mux[N_IN-1:0] = mask_q;
            A_CTRL: begin
                rd_mux[CTRL_EN_BIT]   = cap_en_q;
                rd_mux[CTRL_LAST_BIT] = last_mode_q;
            end
            A_DIV:    rd_mux[DIV_W-1:0] = div_q;
            A_LIMIT:  rd_mux = limit_q;
            A_STATUS: begin
                rd_mux[0] = irq;
                rd_mux[STATUS_LVL_LSB +: LW] = level;
            end
            A_HIST: begin
                rd_mux[N_IN-1:0] = empty ? '0 : head;
                rd_mux[N_IN]     = !empty;
            end
            A_STICKY: rd_mux[N_IN-1:0] = sticky_q;
            A_LIVE:   rd_mux[N_IN-1:0] = sync_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    // R2
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !busy_out);

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_STICKY) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

endmodule

// File: tb/tb_busy_combiner_monitor.sv
module tb_busy_combiner_monitor;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] busy_in;
    logic        busy_out;
    logic        reg_wr, reg_rd;
    logic [2:0]  reg_addr;
    logic [23:0] reg_wdata;
    logic [23:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    logic [23:0] rv;

    always #4 clk = ~clk;

    busy_combiner_monitor dut (
        .clk(clk), .rst_n(rst_n), .busy_in(busy_in), .busy_out(busy_out),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [23:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [23:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog timeout");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic [15:0] pat, msk;
        logic [15:0] pa, pb, pc;
        rst_n = 1'b0; busy_in = '0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 busy_out", busy_out, 0);
        check("R10 irq", irq, 0);
        check("R10 rdata", reg_rdata, 0);
        rd(3'd0, rv); check("R10 mask", rv, 0);
        rd(3'd6, rv); check("R10 sticky", rv, 0);
        rd(3'd4, rv); check("R10 status", rv, 0);
        rd(3'd5, rv); check("R10 hist empty", rv, 0);

        // R1 latency: visible after edge k+1
        busy_in = 16'h0004;
        @(negedge clk);
        check("R1 not before k+1", busy_out, 0);
        @(negedge clk);
        check("R1 at k+1", busy_out, 1);
        rd(3'd7, rv); check("R1 live", rv, 24'h0004);
        busy_in = '0; idle(3);

        // R2 sweep: each input against four mask patterns
        for (int i = 0; i < 16; i++) begin
            for (int m = 0; m < 4; m++) begin
                pat = 16'h1 << i;
                case (m)
                    0: msk = 16'h0000;
                    1: msk = pat;
                    2: msk = ~pat;
                    default: msk = 16'hFFFF;
                endcase
                wr(3'd0, {8'h0, msk});
                busy_in = pat;
                idle(3);
                check("R2 sweep", busy_out, |(pat & ~msk));
            end
        end
        lfsr = 16'hACE1;
        for (int k = 0; k < 24; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pat = lfsr;
            msk = {lfsr[7:0], lfsr[15:8]} | {lfsr[3:0], lfsr[15:4]};
            wr(3'd0, {8'h0, msk});
            busy_in = pat;
            idle(3);
            check("R2 mixed", busy_out, |(pat & ~msk));
        end

        // R3 sticky, independent of mask
        wr(3'd0, 24'h00FFFF);
        busy_in = '0; idle(4);
        wr(3'd6, 24'h00FFFF);
        rd(3'd6, rv); check("R3 cleared", rv, 0);
        busy_in = 16'h0020; idle(3);
        busy_in = '0; idle(4);
        check("R2 all masked", busy_out, 0);
        rd(3'd6, rv); check("R3 set", rv, 24'h0020);
        idle(5);
        rd(3'd6, rv); check("R3 holds", rv, 24'h0020);
        wr(3'd6, 24'h000020);
        rd(3'd6, rv); check("R3 w1c", rv, 0);

        // R8 / R9 watchdog, LIMIT = 20
        wr(3'd0, 24'h0);
        wr(3'd3, 24'd20);
        idle(3);
        wr(3'd4, 24'h1);
        check("R9 cleared", irq, 0);
        busy_in = 16'h0001; idle(10);
        busy_in = '0; idle(5);
        check("R8 short burst", irq, 0);
        busy_in = 16'h0001; idle(15);
        busy_in = '0; idle(3);
        busy_in = 16'h0001; idle(15);
        busy_in = '0; idle(5);
        check("R8 restart after low", irq, 0);
        busy_in = 16'h0001; idle(40);
        check("R8 long busy", irq, 1);
        busy_in = '0; idle(10);
        check("R9 latched", irq, 1);
        rd(3'd4, rv); check("R9 status bit", rv[0], 1);
        wr(3'd4, 24'h1);
        check("R9 clear", irq, 0);

        // R4 / R5 first window, SAMPLE_DIV = 3
        pa = 16'h00F1; pb = 16'h0A02; pc = 16'h8003;
        wr(3'd2, 24'd3);
        busy_in = pa; idle(4);
        wr(3'd1, 24'h5);            // enable, first window, flush at edge e
        idle(15);
        busy_in = pb;
        idle(40);
        rd(3'd4, rv); check("R5 level full", rv[11:8], 8);
        for (int k = 0; k < 8; k++) begin
            rd(3'd5, rv);
            check(k < 4 ? "R4 first window A" : "R4 first window B", rv, {7'h0, 1'b1, (k < 4) ? pa : pb});
        end
        rd(3'd5, rv); check("R7 empty read", rv, 0);
        idle(20);
        rd(3'd4, rv); check("R5 capture stopped", rv[11:8], 0);

        // R6 last window
        busy_in = pa; idle(4);
        wr(3'd1, 24'h7);            // enable, last window, flush at edge e
        idle(15);
        busy_in = pb;
        idle(12);
        busy_in = pc;
        idle(18);
        wr(3'd1, 24'h2);            // disable at edge e+46
        rd(3'd4, rv); check("R6 level", rv[11:8], 8);
        for (int k = 0; k < 8; k++) begin
            rd(3'd5, rv);
            check("R6 last window", rv, {7'h0, 1'b1, (k == 0) ? pa : (k < 4) ? pb : pc});
        end
        rd(3'd4, rv); check("R7 level after pops", rv[11:8], 0);
        rd(3'd5, rv); check("R7 empty again", rv, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule